// File: doc/BRIEF.md
# Synchronous Receive Hunt and Buffer Fill

This block is the receive half of a bit-transparent synchronous serial channel. While enabled it hunts: it compares a 16-bit sliding window of incoming bits with a programmable pair of sync characters. After the pair has been seen it packs each following group of eight bits into a byte. Each byte goes into the receive buffer named by the current entry of a small descriptor table. A buffer closes when it holds its maximum length or when software forces a return to hunt. On close the block reports the buffer index and byte count, marks the entry as no longer empty, optionally raises an interrupt, and moves on to the next entry.

Software fills the descriptor table through a write port. It supplies the two sync characters, a receiver enable, an interrupt enable and a hunt command strobe. Serial bits arrive on a data line qualified by a per-bit strobe, which stands in for the receive clock. Received bytes leave on a write port with buffer index and offset, so an external memory or DMA engine can store them.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset all outputs are low, the receiver is idle and the current descriptor is entry 0. Every table entry resets to not empty, no wrap, length 0. One cycle after `en_i` goes high the receiver starts hunting, using entry 0.
- R2: In hunt, each strobed bit is shifted into a 16-bit window, oldest bit at the top. A sync match needs at least 16 bits shifted since hunt began and a window equal to `{syn1_i, syn2_i}`, so the first character arrives first, MSB first. No byte is written before the match.
- R3: The bits that follow the match are packed MSB first, eight at a time. A completed byte is issued on `wr_o` one cycle after its last bit, carrying the current descriptor index and the buffer's byte count before that byte as `wr_off_o`.
- R4: When the count reaches the entry's maximum length (length 0 means 256), the buffer closes: `close_o` pulses with index and count, and the entry's empty bit is cleared. The current index becomes 0 if the entry's wrap bit is set or it is the last entry, and the next index otherwise.
- R5: A hunt command closes a buffer that holds at least one byte, reporting the partial count, and advances the index as in R4. The receiver then hunts again with a cleared window. A hunt command while the buffer holds no bytes closes nothing and keeps the current descriptor.
- R6: `irq_o` pulses together with `close_o` exactly when `irq_en_i` is high in the closing cycle.
- R7: A byte that completes while the current entry is not empty is dropped. `busy_o` pulses instead of `wr_o`, and the receiver stays on that entry and keeps packing bytes.
- R8: Bits strobed while `en_i` is low are ignored. A receiver that was active and is then disabled stays idle after `en_i` returns high. It leaves idle only after a hunt command, given while disabled or after re-enabling.
- R9: A hunt command takes priority over a bit strobed in the same cycle. That bit is discarded and counts neither toward sync nor toward a byte.
- R10: A descriptor write sets the empty bit, wrap bit and length of the addressed entry. If it hits the entry being closed in the same cycle, the written values win. The close and the index advance still use the entry's previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Receiver enable |
| rxd_i | input | 1 | Serial receive data |
| rxd_vld_i | input | 1 | Strobe: `rxd_i` carries a new bit this cycle |
| syn1_i | input | CHAR_W | First sync character |
| syn2_i | input | CHAR_W | Second sync character |
| hunt_i | input | 1 | Hunt command strobe |
| irq_en_i | input | 1 | Interrupt enable |
| dsc_wr_i | input | 1 | Descriptor write strobe |
| dsc_idx_i | input | IDX_W | Descriptor index to write |
| dsc_empty_i | input | 1 | Empty bit to write |
| dsc_wrap_i | input | 1 | Wrap bit to write |
| dsc_len_i | input | LEN_W | Maximum length to write, 0 means 256 |
| wr_o | output | 1 | Received byte valid |
| wr_idx_o | output | IDX_W | Buffer index of the byte |
| wr_off_o | output | LEN_W | Byte offset inside the buffer |
| wr_data_o | output | CHAR_W | Received byte |
| close_o | output | 1 | Buffer closed |
| close_idx_o | output | IDX_W | Index of the closed buffer |
| close_cnt_o | output | LEN_W+1 | Byte count of the closed buffer |
| irq_o | output | 1 | Receive interrupt pulse |
| busy_o | output | 1 | Byte dropped because the buffer was not empty |

## Verification
The bench aims at the window boundary. A sync pair that lands within the first 15 bits after hunt begins must not match, or the receiver would lock onto stale or reset bits. It sends a hunt command with an empty buffer, which a careless design would answer with a zero-length close that uses up a descriptor. It disables and re-enables the receiver without a hunt command, where a wrong design would resume hunting at once. It sends a hunt command in the same cycle as a data bit, so a design that lets the bit through would sync or pack one bit early. It writes a descriptor in the very cycle that entry closes, and a wrong design would lose either the new values or the old wrap bit.

// File: rtl/shr_pkg.sv
package shr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_DATA = 2'd2
  } rx_state_e;
endpackage

// File: rtl/shr_sync_det.sv
module shr_sync_det #(
  parameter int CHAR_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  bit_vld_i,
  input  logic                  bit_i,
  input  logic [2*CHAR_W-1:0]   pattern_i,
  output logic                  match_o
);
  localparam int WIN_W  = 2 * CHAR_W;
  localparam int FILL_W = $clog2(WIN_W + 1);

  logic [WIN_W-1:0]  win_q, win_nxt;
  logic [FILL_W-1:0] fill_q;

  assign win_nxt = {win_q[WIN_W-2:0], bit_i};
  // window counts only once every position holds a bit seen in this hunt
  assign match_o = bit_vld_i && !clr_i && (fill_q >= FILL_W'(WIN_W - 1)) &&
                   (win_nxt == pattern_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (clr_i) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (bit_vld_i) begin
      win_q <= win_nxt;
      if (fill_q != FILL_W'(WIN_W)) fill_q <= fill_q + 1'b1;
    end
  end

  p_fill_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= FILL_W'(WIN_W));
  p_clr_empties_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> fill_q == '0);
endmodule

// File: rtl/shr_deser.sv
module shr_deser #(
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  output logic              byte_vld_o,
  output logic [CHAR_W-1:0] byte_o
);
  localparam int CNT_W = $clog2(CHAR_W);

  logic [CHAR_W-2:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  assign byte_o     = {sh_q, bit_i};
  assign byte_vld_o = bit_vld_i && !clr_i && (cnt_q == CNT_W'(CHAR_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (bit_vld_i) begin
      sh_q  <= byte_o[CHAR_W-2:0];
      cnt_q <= byte_vld_o ? '0 : cnt_q + 1'b1;
    end
  end

  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(CHAR_W - 1));
  p_byte_restarts_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> cnt_q == '0);
endmodule

// File: rtl/shr_desc_tbl.sv
module shr_desc_tbl #(
  parameter int N_DESC = 4,
  parameter int LEN_W  = 8,
  localparam int IDX_W = $clog2(N_DESC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_empty_i,
  input  logic             wr_wrap_i,
  input  logic [LEN_W-1:0] wr_len_i,
  input  logic             close_i,
  output logic [IDX_W-1:0] cur_idx_o,
  output logic             cur_empty_o,
  output logic [LEN_W-1:0] cur_len_o
);
  logic             empty_q [N_DESC];
  logic             wrap_q  [N_DESC];
  logic [LEN_W-1:0] len_q   [N_DESC];
  logic [IDX_W-1:0] cur_q;

  for (genvar g = 0; g < N_DESC; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        empty_q[g] <= 1'b0;
        wrap_q[g]  <= 1'b0;
        len_q[g]   <= '0;
      end else if (wr_i && wr_idx_i == IDX_W'(g)) begin
        empty_q[g] <= wr_empty_i;
        wrap_q[g]  <= wr_wrap_i;
        len_q[g]   <= wr_len_i;
      end else if (close_i && cur_q == IDX_W'(g)) begin
        empty_q[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '0;
    else if (close_i)
      cur_q <= (wrap_q[cur_q] || cur_q == IDX_W'(N_DESC - 1)) ? '0 : cur_q + 1'b1;
  end

  assign cur_idx_o   = cur_q;
  assign cur_empty_o = empty_q[cur_q];
  assign cur_len_o   = len_q[cur_q];

  p_advance_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_i && !wrap_q[cur_q] && cur_q != IDX_W'(N_DESC - 1)
      |=> cur_q == IDX_W'($past(cur_q) + 1'b1));
  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_i && wrap_q[cur_q] |=> cur_q == '0);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !close_i |=> $stable(cur_q));
endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx
  import shr_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int N_DESC = 4,
  parameter int LEN_W  = 8,
  localparam int IDX_W = $clog2(N_DESC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rxd_i,
  input  logic              rxd_vld_i,
  input  logic [CHAR_W-1:0] syn1_i,
  input  logic [CHAR_W-1:0] syn2_i,
  input  logic              hunt_i,
  input  logic              irq_en_i,
  input  logic              dsc_wr_i,
  input  logic [IDX_W-1:0]  dsc_idx_i,
  input  logic              dsc_empty_i,
  input  logic              dsc_wrap_i,
  input  logic [LEN_W-1:0]  dsc_len_i,
  output logic              wr_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [LEN_W-1:0]  wr_off_o,
  output logic [CHAR_W-1:0] wr_data_o,
  output logic              close_o,
  output logic [IDX_W-1:0]  close_idx_o,
  output logic [LEN_W:0]    close_cnt_o,
  output logic              irq_o,
  output logic              busy_o
);
  localparam int CNT_W = LEN_W + 1;

  rx_state_e        state_q, state_n;
  logic             need_q, need_n;
  logic [CNT_W-1:0] cnt_q, cnt_inc, lim;

  logic             sd_clr, sd_match;
  logic             dz_clr, dz_vld;
  logic [CHAR_W-1:0] dz_byte;
  logic [IDX_W-1:0] cur_idx;
  logic             cur_empty;
  logic [LEN_W-1:0] cur_len;
  logic             take, busy, full_close, hunt_close, close_now;

  assign sd_clr = (state_q != ST_HUNT) || hunt_i || !en_i;
  assign dz_clr = (state_q != ST_DATA) || hunt_i || !en_i;

  shr_sync_det #(.CHAR_W(CHAR_W)) u_sync (
    .clk_i, .rst_ni,
    .clr_i     (sd_clr),
    .bit_vld_i (rxd_vld_i),
    .bit_i     (rxd_i),
    .pattern_i ({syn1_i, syn2_i}),
    .match_o   (sd_match)
  );

  shr_deser #(.CHAR_W(CHAR_W)) u_deser (
    .clk_i, .rst_ni,
    .clr_i      (dz_clr),
    .bit_vld_i  (rxd_vld_i),
    .bit_i      (rxd_i),
    .byte_vld_o (dz_vld),
    .byte_o     (dz_byte)
  );

  shr_desc_tbl #(.N_DESC(N_DESC), .LEN_W(LEN_W)) u_tbl (
    .clk_i, .rst_ni,
    .wr_i        (dsc_wr_i),
    .wr_idx_i    (dsc_idx_i),
    .wr_empty_i  (dsc_empty_i),
    .wr_wrap_i   (dsc_wrap_i),
    .wr_len_i    (dsc_len_i),
    .close_i     (close_now),
    .cur_idx_o   (cur_idx),
    .cur_empty_o (cur_empty),
    .cur_len_o   (cur_len)
  );

  // length 0 stands for a full 2**LEN_W buffer
  assign lim        = (cur_len == '0) ? (CNT_W'(1) << LEN_W) : {1'b0, cur_len};
  assign cnt_inc    = cnt_q + 1'b1;
  assign take       = dz_vld && cur_empty;
  assign busy       = dz_vld && !cur_empty;
  assign full_close = take && (cnt_inc == lim);
  assign hunt_close = hunt_i && (cnt_q != '0);
  assign close_now  = full_close || hunt_close;

  always_comb begin
    state_n = state_q;
    need_n  = need_q;
    if (hunt_i) begin
      state_n = en_i ? ST_HUNT : ST_IDLE;
      need_n  = 1'b0;
    end else if (!en_i) begin
      state_n = ST_IDLE;
      need_n  = need_q || (state_q != ST_IDLE);
    end else if (state_q == ST_IDLE) begin
      state_n = need_q ? ST_IDLE : ST_HUNT;
    end else if (state_q == ST_HUNT && sd_match) begin
      state_n = ST_DATA;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      need_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      need_q  <= need_n;
      if (close_now) cnt_q <= '0;
      else if (take) cnt_q <= cnt_inc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_o        <= 1'b0;
      wr_idx_o    <= '0;
      wr_off_o    <= '0;
      wr_data_o   <= '0;
      close_o     <= 1'b0;
      close_idx_o <= '0;
      close_cnt_o <= '0;
      irq_o       <= 1'b0;
      busy_o      <= 1'b0;
    end else begin
      wr_o    <= take;
      busy_o  <= busy;
      close_o <= close_now;
      irq_o   <= close_now && irq_en_i;
      if (take) begin
        wr_idx_o  <= cur_idx;
        wr_off_o  <= cnt_q[LEN_W-1:0];
        wr_data_o <= dz_byte;
      end
      if (close_now) begin
        close_idx_o <= cur_idx;
        close_cnt_o <= full_close ? cnt_inc : cnt_q;
      end
    end
  end

  p_irq_with_close_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> close_o);
  p_write_in_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $past(state_q) == ST_DATA);
  p_busy_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !wr_o);
  p_hunt_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hunt_i |=> !wr_o && !busy_o && state_q != ST_DATA);
  p_relock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE && need_q && !hunt_i |=> state_q == ST_IDLE);
  p_close_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_o |-> close_cnt_o != '0);
endmodule

// File: tb/sim_sync_hunt_rx.sv
module sim_sync_hunt_rx;
  localparam int CW = 8;
  localparam int ND = 4;
  localparam int LW = 8;
  localparam int IW = $clog2(ND);

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, rxd = 0, vld = 0, hunt = 0, irq_en = 0;
  logic [CW-1:0] syn1 = 8'hB4, syn2 = 8'h3C;
  logic dwe = 0, demp = 0, dwrap = 0;
  logic [IW-1:0] didx = '0;
  logic [LW-1:0] dlen = '0;
  logic wr, cls, irq, bsy;
  logic [IW-1:0] widx, cidx;
  logic [LW-1:0] woff;
  logic [CW-1:0] wdat;
  logic [LW:0] ccnt;

  int n_vec = 0, n_bad = 0, n_wr = 0, n_cls = 0;
  int last_cidx, last_ccnt, last_wdat, last_woff;

  always #4 clk = ~clk;

  sync_hunt_rx #(.CHAR_W(CW), .N_DESC(ND), .LEN_W(LW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .rxd_i(rxd), .rxd_vld_i(vld),
    .syn1_i(syn1), .syn2_i(syn2), .hunt_i(hunt), .irq_en_i(irq_en),
    .dsc_wr_i(dwe), .dsc_idx_i(didx), .dsc_empty_i(demp), .dsc_wrap_i(dwrap),
    .dsc_len_i(dlen), .wr_o(wr), .wr_idx_o(widx), .wr_off_o(woff),
    .wr_data_o(wdat), .close_o(cls), .close_idx_o(cidx), .close_cnt_o(ccnt),
    .irq_o(irq), .busy_o(bsy));

  // reference state
  int m_state = 0, m_fill = 0, m_bits = 0, m_cnt = 0, m_idx = 0;
  bit m_need = 0;
  logic [15:0] m_win = '0;
  logic [7:0] m_sh = '0;
  bit m_emp[ND], m_wrp[ND];
  int m_len[ND];
  bit e_wr, e_cls, e_irq, e_bsy, e_hunt;
  int e_widx, e_off, e_dat, e_cidx, e_ccnt;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit do_cls = 0;
    int cc = 0;
    logic [7:0] b;
    int lim;
    e_wr = 0; e_cls = 0; e_irq = 0; e_bsy = 0; e_hunt = 0;
    if (hunt) begin
      if (m_cnt != 0) begin do_cls = 1; cc = m_cnt; e_hunt = 1; end
      m_need = 0; m_state = en ? 1 : 0; m_fill = 0; m_bits = 0; m_win = '0;
    end else if (!en) begin
      if (m_state != 0) m_need = 1;
      m_state = 0;
    end else if (m_state == 0) begin
      if (!m_need) begin m_state = 1; m_fill = 0; m_bits = 0; m_win = '0; end
    end else if (vld) begin
      if (m_state == 1) begin
        m_win = {m_win[14:0], rxd};
        if (m_fill < 16) m_fill++;
        if (m_fill == 16 && m_win == {syn1, syn2}) begin m_state = 2; m_bits = 0; end
      end else begin
        b = {m_sh[6:0], rxd};
        m_sh = b;
        m_bits++;
        if (m_bits == 8) begin
          m_bits = 0;
          if (m_emp[m_idx]) begin
            e_wr = 1; e_widx = m_idx; e_off = m_cnt; e_dat = int'(b);
            m_cnt++;
            lim = (m_len[m_idx] == 0) ? 256 : m_len[m_idx];
            if (m_cnt == lim) begin do_cls = 1; cc = m_cnt; end
          end else e_bsy = 1;
        end
      end
    end
    if (do_cls) begin
      e_cls = 1; e_cidx = m_idx; e_ccnt = cc; e_irq = irq_en;
      m_emp[m_idx] = 0;
      m_idx = (m_wrp[m_idx] || m_idx == ND - 1) ? 0 : m_idx + 1;
      m_cnt = 0;
    end
    if (dwe) begin
      m_emp[didx] = demp; m_wrp[didx] = dwrap; m_len[didx] = int'(dlen);
    end
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    #2;
    chk(wr == e_wr, "R3", "wr_o", wr, e_wr);
    if (e_wr && wr) begin
      chk(int'(widx) == e_widx, "R3", "wr_idx_o", widx, e_widx);
      chk(int'(woff) == e_off, "R3", "wr_off_o", woff, e_off);
      chk(int'(wdat) == e_dat, "R3", "wr_data_o", wdat, e_dat);
    end
    if (e_hunt) chk(cls == e_cls, "R5", "close_o on hunt", cls, e_cls);
    else        chk(cls == e_cls, "R4", "close_o", cls, e_cls);
    if (e_cls && cls) begin
      chk(int'(cidx) == e_cidx, "R4", "close_idx_o", cidx, e_cidx);
      chk(int'(ccnt) == e_ccnt, "R4", "close_cnt_o", ccnt, e_ccnt);
    end
    chk(irq == e_irq, "R6", "irq_o", irq, e_irq);
    chk(bsy == e_bsy, "R7", "busy_o", bsy, e_bsy);
    if (wr) begin n_wr++; last_wdat = int'(wdat); last_woff = int'(woff); end
    if (cls) begin n_cls++; last_cidx = int'(cidx); last_ccnt = int'(ccnt); end
    hunt = 0; dwe = 0; vld = 0;
  endtask

  task automatic send_bit(bit b);
    vld = 1; rxd = b; step();
  endtask
  task automatic send_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask
  task automatic send_pat();
    send_byte(syn1); send_byte(syn2);
  endtask
  task automatic wr_desc(int i, bit e, bit w, int l);
    dwe = 1; didx = IW'(i); demp = e; dwrap = w; dlen = LW'(l); step();
  endtask
  task automatic do_hunt();
    hunt = 1; step();
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int w0, c0;
    int pend, pend_n;
    void'($urandom(32'h5eed));
    #20;
    // R1: reset state
    chk(!wr && !cls && !irq && !bsy, "R1", "outputs in reset", {wr, cls, irq, bsy}, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #2;
    chk(!wr && !cls && !irq && !bsy, "R1", "outputs after reset", {wr, cls, irq, bsy}, 0);

    // R10: load table
    wr_desc(0, 1, 0, 3); wr_desc(1, 1, 0, 2); wr_desc(2, 1, 0, 4); wr_desc(3, 1, 1, 5);
    irq_en = 1; en = 1; step();
    // R2: noise plus a pattern that straddles too few bits: no write
    send_byte(8'h00); send_bit(1); send_bit(0); send_bit(1);
    chk(n_wr == 0, "R2", "no write before sync", n_wr, 0);
    send_pat();
    w0 = n_wr;
    send_byte(8'h5A);
    chk(n_wr == w0 + 1 && last_wdat == 8'h5A, "R2", "first byte after sync", last_wdat, 8'h5A);
    send_byte(8'hC3); send_byte(8'h0F);
    // R4: full close of entry 0 at length 3
    chk(last_cidx == 0 && last_ccnt == 3, "R4", "full close count", last_ccnt, 3);

    // R5: partial buffer in entry 1 closed by hunt
    send_byte(8'h77);
    c0 = n_cls;
    do_hunt();
    chk(n_cls == c0 + 1 && last_cidx == 1 && last_ccnt == 1, "R5", "partial close", last_ccnt, 1);
    // R5: hunt with empty buffer closes nothing
    c0 = n_cls;
    do_hunt();
    chk(n_cls == c0, "R5", "no close on empty buffer", n_cls, c0);

    // R9: hunt in the same cycle as the last sync bit
    send_byte(syn1);
    for (int i = 7; i >= 1; i--) send_bit(syn2[i]);
    vld = 1; rxd = syn2[0]; hunt = 1; step();
    w0 = n_wr;
    send_byte(8'hAA);
    chk(n_wr == w0, "R9", "bit under hunt ignored", n_wr, w0);

    // R7 then R10: entry 2 marked not empty, then re-armed
    wr_desc(2, 0, 0, 4);
    send_pat();
    w0 = n_wr;
    send_byte(8'h11);
    chk(n_wr == w0, "R7", "byte dropped when busy", n_wr, w0);
    wr_desc(2, 1, 0, 4);
    send_byte(8'h22);
    chk(n_wr == w0 + 1 && last_woff == 0, "R10", "rearmed entry takes byte", last_woff, 0);

    // R8: disable, re-enable without hunt stays idle
    en = 0; step();
    en = 1; step();
    send_pat();
    w0 = n_wr;
    send_byte(8'h33);
    chk(n_wr == w0, "R8", "idle until hunt", n_wr, w0);
    c0 = n_cls;
    do_hunt();
    chk(n_cls == c0 + 1 && last_ccnt == 1, "R8", "hunt closes stale buffer", last_ccnt, 1);
    step();
    send_pat(); send_byte(8'h44);
    chk(n_wr == w0 + 1 && last_wdat == 8'h44, "R8", "resumes after hunt", last_wdat, 8'h44);

    // random phase
    pend = 0; pend_n = 0;
    for (int it = 0; it < 25000; it++) begin
      int r;
      r = int'($urandom % 1000);
      if (r < 6) en = ~en;
      if (r >= 6 && r < 26) hunt = 1;
      if (r >= 26 && r < 30) irq_en = ~irq_en;
      if (int'($urandom % 100) < 4) begin
        dwe = 1; didx = IW'($urandom % ND);
        demp = (int'($urandom % 4) != 0);
        dwrap = (int'($urandom % 5) == 0);
        dlen = (int'($urandom % 200) == 0) ? '0 : LW'(1 + $urandom % 6);
      end
      if (pend_n == 0 && int'($urandom % 100) < 3) begin
        pend = int'({syn1, syn2}); pend_n = 16;
      end
      if (int'($urandom % 10) < 8) begin
        vld = 1;
        if (pend_n > 0) begin rxd = pend[pend_n - 1]; pend_n--; end
        else rxd = $urandom % 2;
      end
      step();
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule